// File: doc/BRIEF.md
# Memory Card Command Issue and Response Capture

This block sits between a register write port and the card side of a memory card host controller. A 16-bit command word written to it is split into a command index, response kind, command class, transfer direction, busy-wait flag and an initialisation flag. The block then sends a single request, carrying a 32-bit argument built from two separately written 16-bit halves, to a byte-parallel card port. It stays in a waiting phase until the card answers.

When the answer arrives, the block stores the response bytes into eight 16-bit response words, in word-reversed order. It then evaluates the answer according to the response kind and sets bits in a 16-bit status register. The status bits report command completion, busy completion, a missing response, OCR power-up busy and card-reported errors. Status bits are cleared by writing ones to them. A single interrupt line is raised whenever a status bit is set whose enable bit is also set in a 15-bit mask.

Serial line signalling and CRC handling are not part of this block. The card side delivers all response bytes at once together with a byte count.

Top module: `mmc_cmd_host`

## Requirements
- R1: Writes to address 1 replace argument bits 15:0 and writes to address 2 replace argument bits 31:16. Each write leaves the other half unchanged. The argument value held at the time of issue appears on `card_arg`.
- R2: A command word written to address 0 while idle is decoded as follows: bits 5:0 are the index, bit 7 is the init flag, bits 10:8 are the response kind (0 none, 1 short status, 2 long 16-byte, 3 OCR, 6 published address), bit 11 is busy-wait, bits 13:12 are the class and bit 15 is the direction. Unless R3 applies, the cycle after the write shows `card_req` high for exactly one cycle, with the index, class and direction on the card port.
- R3: A command word with the init flag set and index 0 sends no request and sets only status bit 0. An init-flagged word with any other index is issued normally.
- R4: When a command is issued, all response words clear to zero. When the answer is accepted without a timeout, response word j takes bytes 14-2j (high half) and 15-2j (low half) of the response. Byte 0 is `card_rsp_data[127:120]`.
- R5: The expected byte count is 0 for kind none, 16 for the long kind and 4 for all other kinds. An answer shorter than expected sets status bits 7 and 0, runs no other check and leaves the response words at zero.
- R6: For the short status kind, response bytes 0..3 form a big-endian 32-bit card status. If that status intersects 0xFDF90000, status bit 14 is set. When `auth_chk_en` is high, card status bit 3 also counts as an error.
- R7: A short status command with the busy-wait flag set ends with status bits 0 and 2 set, unless it timed out.
- R8: For the OCR kind, status bit 12 is set when bit 31 of the big-endian 32-bit value is clear.
- R9: For the published address kind, only bytes 2 and 3 are examined. Status bit 14 is set if they intersect 0xE000, or bit 3 when `auth_chk_en` is high.
- R10: Every accepted answer sets status bit 0. Writing to address 3 clears each status bit written as 1. A bit that is set and cleared in the same cycle stays set. Only status bits 0, 2, 7, 12 and 14 are ever set.
- R11: Writes to address 4 load mask bits 14:0, and mask bit 15 always reads 0. `irq` is high exactly when status and mask share a set bit, and it reflects a status or mask write in the following cycle.
- R12: A command word written while an answer is still awaited is ignored: no new request is sent and the card port fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 command, 1 arg low, 2 arg high, 3 status clear, 4 mask |
| wr_data | input | 16 | Register write data |
| auth_chk_en | input | 1 | Adds card status bit 3 to the error checks |
| card_req | output | 1 | One-cycle command request to the card |
| card_idx | output | 6 | Command index of the request |
| card_arg | output | 32 | Command argument of the request |
| card_kind | output | 2 | Command class of the request |
| card_dir | output | 1 | Transfer direction of the request |
| card_rsp_valid | input | 1 | Card answer present |
| card_rsp_len | input | 5 | Number of answer bytes, 0 for none |
| card_rsp_data | input | 128 | Answer bytes, byte 0 in the top eight bits |
| rsp_sel | input | 3 | Response word select |
| rsp_word | output | 16 | Selected response word |
| status | output | 16 | Status register |
| irq_mask | output | 16 | Interrupt enable mask, bit 15 always 0 |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. A request never lasts more than one cycle, and an init index-0 command never produces one. A missing-response or busy-end flag never rises without the completion flag. A clear write removes the written bits unless a completion lands in the same cycle. The mask follows its last write, and no undefined status bit is ever set. The decode and evaluation rules for each response kind need the bench's scenarios. Those scenarios cover the error masks with and without the authentication bit, OCR busy, short answers, word-reversed storage, set-over-clear priority and commands ignored while a request is outstanding.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

   localparam logic [2:0] RSP_NONE  = 3'd0;
   localparam logic [2:0] RSP_SHORT = 3'd1;
   localparam logic [2:0] RSP_LONG  = 3'd2;
   localparam logic [2:0] RSP_OCR   = 3'd3;
   localparam logic [2:0] RSP_RCA   = 3'd6;

   localparam logic [2:0] ADR_CMD    = 3'd0;
   localparam logic [2:0] ADR_ARG_LO = 3'd1;
   localparam logic [2:0] ADR_ARG_HI = 3'd2;
   localparam logic [2:0] ADR_STAT   = 3'd3;
   localparam logic [2:0] ADR_MASK   = 3'd4;

   localparam int ST_DONE     = 0;
   localparam int ST_BUSY_END = 2;
   localparam int ST_NO_RSP   = 7;
   localparam int ST_OCR_BUSY = 12;
   localparam int ST_CARD_ERR = 14;

   typedef struct packed {
      logic       dir;
      logic [1:0] kind;
      logic       busy;
      logic [2:0] rsp;
      logic       init;
      logic [5:0] idx;
   } cmd_fields_t;

   typedef enum logic {PH_IDLE, PH_WAIT} phase_e;

   function automatic int unsigned want_bytes(input logic [2:0] rsp, input int unsigned long_n);
      case (rsp)
         RSP_NONE: return 0;
         RSP_LONG: return long_n;
         default:  return 4;
      endcase
   endfunction

endpackage

// File: rtl/mmc_cmd_decode.sv
module mmc_cmd_decode
   import mmc_cmd_pkg::*;
(
   input  logic [15:0] cmd_word,
   output cmd_fields_t fields,
   output logic        boot_only
);
   assign fields.idx  = cmd_word[5:0];
   assign fields.init = cmd_word[7];
   assign fields.rsp  = cmd_word[10:8];
   assign fields.busy = cmd_word[11];
   assign fields.kind = cmd_word[13:12];
   assign fields.dir  = cmd_word[15];

   assign boot_only = fields.init && (fields.idx == 6'd0);

   logic unused_cmd_bits;
   assign unused_cmd_bits = cmd_word[6] ^ cmd_word[14];
endmodule

// File: rtl/mmc_rsp_store.sv
module mmc_rsp_store #(
   parameter int WORD_W  = 16,
   parameter int N_WORDS = 8,
   localparam int SEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
   localparam int BUS_W  = WORD_W * N_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [BUS_W-1:0]  bus,
   input  logic [SEL_W-1:0]  sel,
   output logic [WORD_W-1:0] word
);
   logic [WORD_W-1:0] regs [N_WORDS];

   for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)    regs[g] <= '0;
         else if (load) regs[g] <= bus[g*WORD_W +: WORD_W];
         else if (clr)  regs[g] <= '0;
      end
   end

   assign word = regs[sel];
endmodule

// File: rtl/mmc_rsp_eval.sv
module mmc_rsp_eval
   import mmc_cmd_pkg::*;
#(
   parameter int          RSP_BYTES = 16,
   parameter logic [31:0] ERR_MASK  = 32'hFDF9_0000,
   parameter logic [15:0] RCA_MASK  = 16'hE000,
   parameter int          AUTH_BIT  = 3,
   parameter int          ST_W      = 16,
   localparam int         LEN_W     = $clog2(RSP_BYTES + 1)
) (
   input  logic [2:0]      rsp,
   input  logic            busy,
   input  logic [LEN_W-1:0] len,
   input  logic [31:0]     head,
   input  logic            auth_en,
   output logic            keep,
   output logic [ST_W-1:0] set_bits
);
   logic [31:0] auth_vec;
   logic        too_short;

   assign auth_vec  = auth_en ? (32'd1 << AUTH_BIT) : 32'd0;
   assign too_short = 32'(len) < want_bytes(rsp, RSP_BYTES);
   assign keep      = !too_short;

   always_comb begin
      set_bits          = '0;
      set_bits[ST_DONE] = 1'b1;
      if (too_short) begin
         set_bits[ST_NO_RSP] = 1'b1;
      end else begin
         case (rsp)
            RSP_SHORT: begin
               if (busy) set_bits[ST_BUSY_END] = 1'b1;
               if ((head & (ERR_MASK | auth_vec)) != 32'd0) set_bits[ST_CARD_ERR] = 1'b1;
            end
            RSP_OCR: begin
               if (!head[31]) set_bits[ST_OCR_BUSY] = 1'b1;
            end
            RSP_RCA: begin
               if ((head[15:0] & (RCA_MASK | auth_vec[15:0])) != 16'd0) set_bits[ST_CARD_ERR] = 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mmc_stat_irq.sv
module mmc_stat_irq #(
   parameter int ST_W   = 16,
   parameter int MASK_W = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [ST_W-1:0] set_bits,
   input  logic            clr_en,
   input  logic [ST_W-1:0] clr_bits,
   input  logic            mask_en,
   input  logic [ST_W-1:0] mask_in,
   output logic [ST_W-1:0] status,
   output logic [ST_W-1:0] mask,
   output logic            irq
);
   logic [MASK_W-1:0] mask_q;
   logic [ST_W-1:0]   clr_vec, set_vec;

   assign clr_vec = clr_en ? clr_bits : '0;
   assign set_vec = set_en ? set_bits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         mask_q <= '0;
      end else begin
         status <= (status & ~clr_vec) | set_vec;
         if (mask_en) mask_q <= mask_in[MASK_W-1:0];
      end
   end

   assign mask = ST_W'(mask_q);
   assign irq  = |(status & mask);

   logic unused_mask_bits;
   assign unused_mask_bits = ^mask_in[ST_W-1:MASK_W];
endmodule

// File: rtl/mmc_cmd_host.sv
module mmc_cmd_host
   import mmc_cmd_pkg::*;
#(
   parameter int          WORD_W    = 16,
   parameter int          RSP_WORDS = 8,
   parameter int          MASK_W    = 15,
   parameter int          AUTH_BIT  = 3,
   parameter logic [31:0] ERR_MASK  = 32'hFDF9_0000,
   parameter logic [15:0] RCA_MASK  = 16'hE000,
   localparam int         ARG_W     = 2 * WORD_W,
   localparam int         RSP_BITS  = RSP_WORDS * WORD_W,
   localparam int         RSP_BYTES = RSP_BITS / 8,
   localparam int         LEN_W     = $clog2(RSP_BYTES + 1),
   localparam int         SEL_W     = (RSP_WORDS > 1) ? $clog2(RSP_WORDS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_addr,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                auth_chk_en,
   output logic                card_req,
   output logic [5:0]          card_idx,
   output logic [ARG_W-1:0]    card_arg,
   output logic [1:0]          card_kind,
   output logic                card_dir,
   input  logic                card_rsp_valid,
   input  logic [LEN_W-1:0]    card_rsp_len,
   input  logic [RSP_BITS-1:0] card_rsp_data,
   input  logic [SEL_W-1:0]    rsp_sel,
   output logic [WORD_W-1:0]   rsp_word,
   output logic [WORD_W-1:0]   status,
   output logic [WORD_W-1:0]   irq_mask,
   output logic                irq
);
   initial begin
      assert (WORD_W == 16) else $error("command word must be 16 bits");
      assert (RSP_BYTES >= 4) else $error("response too narrow for a status word");
      assert (MASK_W < WORD_W) else $error("mask must be narrower than status");
      assert (AUTH_BIT < 16) else $error("auth bit outside the low half");
   end

   phase_e      phase;
   cmd_fields_t dec, cur;
   logic        boot_only, cmd_we, issue, rsp_done, keep;
   logic [ARG_W-1:0]  arg_q;
   logic [WORD_W-1:0] eval_bits, set_bits;

   mmc_cmd_decode u_dec (.cmd_word(wr_data), .fields(dec), .boot_only(boot_only));

   assign cmd_we   = wr_en && (wr_addr == ADR_CMD) && (phase == PH_IDLE);
   assign issue    = cmd_we && !boot_only;
   assign rsp_done = (phase == PH_WAIT) && card_rsp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         card_req <= 1'b0;
         cur      <= '0;
         arg_q    <= '0;
         card_arg <= '0;
      end else begin
         card_req <= 1'b0;
         if (wr_en && wr_addr == ADR_ARG_LO) arg_q[WORD_W-1:0]     <= wr_data;
         if (wr_en && wr_addr == ADR_ARG_HI) arg_q[ARG_W-1:WORD_W] <= wr_data;
         if (issue) begin
            phase    <= PH_WAIT;
            card_req <= 1'b1;
            cur      <= dec;
            card_arg <= arg_q;
         end else if (rsp_done) begin
            phase <= PH_IDLE;
         end
      end
   end

   assign card_idx  = cur.idx;
   assign card_kind = cur.kind;
   assign card_dir  = cur.dir;

   mmc_rsp_eval #(
      .RSP_BYTES(RSP_BYTES), .ERR_MASK(ERR_MASK), .RCA_MASK(RCA_MASK),
      .AUTH_BIT(AUTH_BIT), .ST_W(WORD_W)
   ) u_eval (
      .rsp(cur.rsp), .busy(cur.busy), .len(card_rsp_len),
      .head(card_rsp_data[RSP_BITS-1 -: 32]), .auth_en(auth_chk_en),
      .keep(keep), .set_bits(eval_bits)
   );

   mmc_rsp_store #(.WORD_W(WORD_W), .N_WORDS(RSP_WORDS)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(issue), .load(rsp_done && keep),
      .bus(card_rsp_data), .sel(rsp_sel), .word(rsp_word)
   );

   assign set_bits = rsp_done ? eval_bits : WORD_W'(1 << ST_DONE);

   mmc_stat_irq #(.ST_W(WORD_W), .MASK_W(MASK_W)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .set_en(rsp_done || (cmd_we && boot_only)), .set_bits(set_bits),
      .clr_en(wr_en && wr_addr == ADR_STAT), .clr_bits(wr_data),
      .mask_en(wr_en && wr_addr == ADR_MASK), .mask_in(wr_data),
      .status(status), .mask(irq_mask), .irq(irq)
   );
endmodule

// File: rtl/mmc_cmd_host_chk.sv
module mmc_cmd_host_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [2:0]  wr_addr,
   input logic [15:0] wr_data,
   input logic        card_req,
   input logic        card_rsp_valid,
   input logic [15:0] status,
   input logic [15:0] irq_mask,
   input logic        irq
);
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      card_req |=> !card_req);  // R2

   AST_INIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd0 && wr_data[7] && wr_data[5:0] == 6'd0) |=> !card_req);  // R3

   AST_NO_RSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[7]) |-> status[0]);  // R5

   AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[2]) |-> status[0]);  // R7

   AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd3 && !card_rsp_valid) |=> ((status & $past(wr_data)) == 16'd0));  // R10

   AST_KNOWN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~16'h5085) == 16'd0);  // R10

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd4) |=> (irq_mask == {1'b0, $past(wr_data[14:0])}));  // R11

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask == 16'd0) |-> !irq);  // R11
endmodule

bind mmc_cmd_host mmc_cmd_host_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .card_req(card_req), .card_rsp_valid(card_rsp_valid), .status(status),
   .irq_mask(irq_mask), .irq(irq)
);

// File: tb/tb_mmc_cmd_host.sv
module tb_mmc_cmd_host;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [15:0]  wr_data = '0;
   logic         auth_chk_en = 1'b0;
   logic         card_req;
   logic [5:0]   card_idx;
   logic [31:0]  card_arg;
   logic [1:0]   card_kind;
   logic         card_dir;
   logic         card_rsp_valid = 1'b0;
   logic [4:0]   card_rsp_len = '0;
   logic [127:0] card_rsp_data = '0;
   logic [2:0]   rsp_sel = '0;
   logic [15:0]  rsp_word, status, irq_mask;
   logic         irq;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   mmc_cmd_host dut (.*);

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
   end

   function automatic int need_len(input logic [2:0] rt);
      if (rt == 3'd0) return 0;
      if (rt == 3'd2) return 16;
      return 4;
   endfunction

   function automatic logic [15:0] model(input logic [2:0] rt, input logic busy, input int len,
                                         input logic [31:0] head, input logic auth);
      logic [15:0] v = 16'h0001;
      logic [31:0] am = auth ? 32'h8 : 32'h0;
      if (len < need_len(rt)) return v | 16'h0080;
      if (rt == 3'd1 && busy) v |= 16'h0004;
      if (rt == 3'd1 && (head & (32'hFDF9_0000 | am)) != 0) v |= 16'h4000;
      if (rt == 3'd3 && !head[31]) v |= 16'h1000;
      if (rt == 3'd6 && (head[15:0] & (16'hE000 | am[15:0])) != 0) v |= 16'h4000;
      return v;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reply(input int len, input logic [127:0] d);
      card_rsp_valid = 1'b1; card_rsp_len = 5'(len); card_rsp_data = d;
      @(negedge clk);
      card_rsp_valid = 1'b0;
   endtask

   task automatic read_rsp(output logic [127:0] v);
      for (int j = 0; j < 8; j++) begin
         rsp_sel = 3'(j);
         #1;
         v[16*j +: 16] = rsp_word;
      end
   endtask

   function automatic logic [15:0] cmd_word(input logic dir, input logic [1:0] kind, input logic busy,
                                            input logic [2:0] rt, input logic init, input logic [5:0] idx);
      return {dir, 1'b0, kind, busy, rt, init, 1'b0, idx};
   endfunction

   initial begin
      logic [127:0] rv, d;
      logic [2:0]   kinds [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6};
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R10 reset status", status, 0);
      chk("R11 reset irq", {irq_mask, irq}, 0);
      chk("R2 reset card_req", card_req, 0);
      read_rsp(rv);
      chk("R4 reset response", rv, 0);

      // R3: init with index 0 is local only
      wr(3'd0, cmd_word(0, 2'd0, 0, 3'd1, 1, 6'd0));
      chk("R3 init cmd0 no request", card_req, 0);
      chk("R3 init cmd0 status", status, 16'h0001);
      wr(3'd3, 16'hFFFF);

      // R3: init with nonzero index is issued
      wr(3'd0, cmd_word(0, 2'd0, 0, 3'd0, 1, 6'd5));
      chk("R3 init idx5 issued", {card_req, card_idx}, {1'b1, 6'd5});
      reply(0, '0);
      chk("R3 init idx5 done", status, 16'h0001);
      wr(3'd3, 16'hFFFF);

      // R1: halves replace only themselves
      wr(3'd1, 16'h1234); wr(3'd2, 16'hABCD); wr(3'd1, 16'h5678);
      wr(3'd0, cmd_word(1, 2'd2, 0, 3'd2, 0, 6'd17));
      chk("R1 argument halves", card_arg, 32'hABCD_5678);
      chk("R2 fields", {card_req, card_idx, card_kind, card_dir}, {1'b1, 6'd17, 2'd2, 1'b1});
      @(negedge clk);
      chk("R2 request one cycle", card_req, 0);
      d = 128'h00112233_44556677_8899AABB_CCDDEEFF;
      reply(16, d);
      read_rsp(rv);
      chk("R4 word reversed", rv, d);
      chk("R4 word0 bytes 14,15", rv[15:0], 16'hEEFF);

      // R4: cleared on issue, R5 short answer keeps zero
      wr(3'd3, 16'hFFFF);
      wr(3'd0, cmd_word(0, 2'd0, 0, 3'd1, 0, 6'd13));
      read_rsp(rv);
      chk("R4 cleared on issue", rv, 0);
      reply(2, {128{1'b1}});
      read_rsp(rv);
      chk("R5 short answer not stored", rv, 0);
      chk("R5 timeout status", status, 16'h0081);

      // R10: partial clear
      wr(3'd3, 16'h0080);
      chk("R10 partial clear", status, 16'h0001);
      wr(3'd3, 16'hFFFF);

      // R12: command ignored while waiting
      wr(3'd0, cmd_word(0, 2'd1, 0, 3'd1, 0, 6'd9));
      wr(3'd0, cmd_word(1, 2'd3, 0, 3'd1, 0, 6'd33));
      chk("R12 ignored while waiting", {card_req, card_idx, card_kind, card_dir}, {1'b0, 6'd9, 2'd1, 1'b0});
      reply(4, '0);
      chk("R12 first command completes", status, 16'h0001);

      // R10: set wins over clear in same cycle
      wr(3'd3, 16'hFFFF);
      wr(3'd0, cmd_word(0, 2'd0, 1, 3'd1, 0, 6'd7));
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'hFFFF;
      reply(4, '0);
      wr_en = 1'b0;
      chk("R10 set wins over clear", status, 16'h0005);

      // R11: mask top bit not writable
      wr(3'd4, 16'hFFFF);
      chk("R11 mask bit15", {irq_mask, irq}, {16'h7FFF, 1'b1});
      wr(3'd4, 16'h0000);
      chk("R11 irq drops after mask", irq, 0);
      wr(3'd3, 16'hFFFF);

      // R6/R9 auth bit directed
      auth_chk_en = 1'b0;
      wr(3'd0, cmd_word(0, 2'd0, 0, 3'd1, 0, 6'd1));
      reply(4, {32'h0000_0008, 96'h0});
      chk("R6 auth bit ignored when off", status, 16'h0001);
      wr(3'd3, 16'hFFFF);
      auth_chk_en = 1'b1;
      wr(3'd0, cmd_word(0, 2'd0, 0, 3'd6, 0, 6'd3));
      reply(4, {32'hFFFF_0008, 96'h0});
      chk("R9 auth bit in low half", status, 16'h4001);
      wr(3'd3, 16'hFFFF);

      // random mix, R6 R7 R8 R9 R5 R11
      for (int it = 0; it < 60; it++) begin
         logic [2:0]  rt   = kinds[$urandom % 5];
         logic        busy = 1'($urandom);
         logic [5:0]  idx  = 6'($urandom);
         logic [1:0]  kind = 2'($urandom);
         logic        dir  = 1'($urandom);
         logic [31:0] arg  = $urandom;
         logic [15:0] m    = 16'($urandom);
         logic [15:0] es;
         int          len;
         int          pick = $urandom % 3;
         d = {$urandom, $urandom, $urandom, $urandom};
         if ($urandom % 2) d[127:96] = d[127:96] & 32'h0206_FF0F;
         if ($urandom % 2) d[111:96] = d[111:96] & 16'h1FF7;
         auth_chk_en = 1'($urandom);
         len = (pick == 0) ? need_len(rt) : (pick == 1) ? 16 :
               (need_len(rt) == 0 ? 0 : int'($urandom % need_len(rt)));
         wr(3'd1, arg[15:0]); wr(3'd2, arg[31:16]);
         wr(3'd0, cmd_word(dir, kind, busy, rt, 0, idx));
         chk("R2 random request", {card_req, card_idx, card_kind, card_dir, card_arg},
             {1'b1, idx, kind, dir, arg});
         reply(len, d);
         es = model(rt, busy, len, d[127:96], auth_chk_en);
         chk("R6 R7 R8 R9 random status", status, es);
         read_rsp(rv);
         chk("R4 R5 random response", rv, (len < need_len(rt)) ? 128'h0 : d);
         wr(3'd4, m);
         chk("R11 random irq", {irq_mask, irq}, {1'b0, m[14:0], |(es & {1'b0, m[14:0]})});
         wr(3'd3, 16'hFFFF);
      end

      report();
   end
endmodule